// File: doc/BRIEF.md
# Compare Flags and Branch Resolver

This block turns a compare operation into a set of held status flags and uses those flags to decide the conditional jumps that follow. A compare supplies a first operand (an immediate or a register value) and a second register value. The block subtracts the first from the second and records three flags: zero, negative and overflow. The flags stay unchanged until the next compare.

A branch request supplies a condition code, a target address, the current program counter and the length of the branch instruction. One cycle later the block reports whether the branch is taken and which address the program counter should hold next. That address is the target when the branch is taken, and the sequential address when it is not.

Top module: `cmp_branch_unit`

## Requirements
- R1: A compare with equal operands sets Z and clears N and OV.
- R2: A compare whose second operand is larger than the first, read as two's-complement values, leaves Z and N clear.
- R3: A compare whose first operand is larger than the second, read as two's-complement values, sets N and clears Z.
- R4: OV is set when second minus first overflows in signed DATA_W-bit arithmetic. N still gives the true signed ordering in that case, as described in R3.
- R5: All three flags are zero after reset. They change only in the cycle after a compare strobe.
- R6: Condition code 0 (unconditional) is always taken, and the next program counter equals the target.
- R7: Condition code 1 (equal) is taken exactly when Z is set. Condition code 2 (not equal) is taken exactly when Z is clear.
- R8: Condition code 3 (less than) is taken exactly when Z and N are both clear. Condition code 4 (greater than) is taken exactly when N is set.
- R9: Condition codes 5, 6 and 7 are never taken.
- R10: When a branch is not taken, the next program counter equals the current program counter plus the instruction length, modulo 2^ADDR_W.
- R11: br_done pulses high for exactly the one cycle after each branch strobe. br_taken and br_next_pc keep their last values when no branch is strobed, and they are zero after reset.
- R12: A branch strobed in the same cycle as a compare is decided on the flags that were held before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_valid | input | 1 | Compare strobe |
| cmp_first | input | DATA_W | First compare operand (immediate or register value) |
| cmp_second | input | DATA_W | Second compare operand (register value) |
| br_valid | input | 1 | Branch strobe |
| br_cond | input | 3 | Condition code (0 always, 1 eq, 2 ne, 3 lt, 4 gt) |
| br_target | input | ADDR_W | Jump target address |
| pc_cur | input | ADDR_W | Program counter of the branch |
| instr_len | input | LEN_W | Length of the branch instruction |
| flag_ov | output | 1 | Held overflow flag |
| flag_z | output | 1 | Held zero flag |
| flag_n | output | 1 | Held negative flag |
| br_done | output | 1 | Branch result valid this cycle |
| br_taken | output | 1 | Branch was taken |
| br_next_pc | output | ADDR_W | Resolved next program counter |

## Verification
The compare and the branch can both be strobed in the same cycle. In that cycle the flags are being overwritten while the branch is reading them. The bench forces this collision in directed steps: it chooses the earlier compare and the new compare so that they lead to opposite branch decisions. Random traffic then raises both strobes often. The behavioural model decides each branch on the flags it held before applying the compare, and a taken result or target that came from the new flags is reported under R12.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    COND_ALWAYS = 3'd0,
    COND_EQ     = 3'd1,
    COND_NE     = 3'd2,
    COND_LT     = 3'd3,
    COND_GT     = 3'd4
  } cond_e;

  typedef struct packed {
    logic ov;
    logic z;
    logic n;
  } flags_t;

endpackage

// File: rtl/cbr_flag_eval.sv
module cbr_flag_eval
  import cbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] first_op,
  input  logic [DATA_W-1:0] second_op,
  output flags_t            flags
);

  localparam int MSB = DATA_W - 1;

  // second - first; N is the sign corrected by overflow
  function automatic flags_t compare_fn(input logic [DATA_W-1:0] a,
                                        input logic [DATA_W-1:0] b);
    flags_t      f;
    logic [DATA_W-1:0] diff;
    diff = b - a;
    f.ov = (a[MSB] != b[MSB]) && (diff[MSB] != b[MSB]);
    f.z  = (diff == '0);
    f.n  = diff[MSB] ^ f.ov;
    return f;
  endfunction

  assign flags = compare_fn(first_op, second_op);

endmodule

// File: rtl/cbr_flag_reg.sv
module cbr_flag_reg
  import cbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  flags_t d,
  output flags_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R5: flags only move after a compare strobe
  assert_flags_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/cbr_cond_check.sv
module cbr_cond_check
  import cbr_pkg::*;
(
  input  logic [2:0] cond,
  input  flags_t     flags,
  output logic       taken
);

  always_comb begin
    case (cond)
      COND_ALWAYS: taken = 1'b1;
      COND_EQ:     taken = flags.z;
      COND_NE:     taken = !flags.z;
      COND_LT:     taken = !flags.z && !flags.n;
      COND_GT:     taken = flags.n;
      default:     taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_valid,
  input  logic [DATA_W-1:0] cmp_first,
  input  logic [DATA_W-1:0] cmp_second,
  input  logic              br_valid,
  input  logic [2:0]        br_cond,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [LEN_W-1:0]  instr_len,
  output logic              flag_ov,
  output logic              flag_z,
  output logic              flag_n,
  output logic              br_done,
  output logic              br_taken,
  output logic [ADDR_W-1:0] br_next_pc
);

  flags_t            flags_new;
  flags_t            flags_cur;
  logic              taken_now;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] pc_pick;

  cbr_flag_eval #(.DATA_W(DATA_W)) u_eval (
    .first_op  (cmp_first),
    .second_op (cmp_second),
    .flags     (flags_new)
  );

  cbr_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmp_valid),
    .d     (flags_new),
    .q     (flags_cur)
  );

  // decided on the held flags, so a same-cycle compare is not seen
  cbr_cond_check u_cond (
    .cond  (br_cond),
    .flags (flags_cur),
    .taken (taken_now)
  );

  assign seq_pc  = pc_cur + ADDR_W'(instr_len);
  assign pc_pick = taken_now ? br_target : seq_pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_done    <= 1'b0;
      br_taken   <= 1'b0;
      br_next_pc <= '0;
    end else begin
      br_done <= br_valid;
      if (br_valid) begin
        br_taken   <= taken_now;
        br_next_pc <= pc_pick;
      end
    end
  end

  assign flag_ov = flags_cur.ov;
  assign flag_z  = flags_cur.z;
  assign flag_n  = flags_cur.n;

  assert_eq_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && (cmp_first == cmp_second) |=> flag_z && !flag_n && !flag_ov);

  assert_z_n_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_z && flag_n));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> br_done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> !br_done && $stable(br_taken) && $stable(br_next_pc));

  assert_always_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && (br_cond == 3'd0) |=> br_taken && (br_next_pc == $past(br_target)));

  assert_never_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && (br_cond > 3'd4) |=> !br_taken);

  assert_seq_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    br_done && !br_taken |-> br_next_pc == $past(pc_cur) + ADDR_W'($past(instr_len)));

endmodule

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_valid = 1'b0;
  logic [DW-1:0] cmp_first = '0;
  logic [DW-1:0] cmp_second = '0;
  logic          br_valid = 1'b0;
  logic [2:0]    br_cond = '0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] pc_cur = '0;
  logic [LW-1:0] instr_len = '0;
  logic          flag_ov, flag_z, flag_n, br_done, br_taken;
  logic [AW-1:0] br_next_pc;

  int checks = 0;
  int failures = 0;

  // reference state
  bit m_ov, m_z, m_n, m_done, m_taken;
  int m_pc;
  string flag_tag, br_tag;

  always #5 clk = ~clk;

  cmp_branch_unit #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_first(cmp_first),
    .cmp_second(cmp_second), .br_valid(br_valid), .br_cond(br_cond),
    .br_target(br_target), .pc_cur(pc_cur), .instr_len(instr_len),
    .flag_ov(flag_ov), .flag_z(flag_z), .flag_n(flag_n), .br_done(br_done),
    .br_taken(br_taken), .br_next_pc(br_next_pc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sx(input logic [DW-1:0] v);
    return (v >= (1 << (DW - 1))) ? int'(v) - (1 << DW) : int'(v);
  endfunction

  // advance one clock: update the model from the inputs, then compare at negedge
  task automatic step();
    int  a, b, d;
    bit  tk;
    bit  both;
    @(posedge clk);
    both = cmp_valid && br_valid;
    if (br_valid) begin
      case (br_cond)
        3'd0: tk = 1;
        3'd1: tk = m_z;
        3'd2: tk = !m_z;
        3'd3: tk = !m_z && !m_n;
        3'd4: tk = m_n;
        default: tk = 0;
      endcase
      m_taken = tk;
      m_pc = tk ? int'(br_target) : (int'(pc_cur) + int'(instr_len)) % (1 << AW);
      if (both) br_tag = "R12";
      else if (br_cond == 3'd0) br_tag = "R6";
      else if (br_cond <= 3'd2) br_tag = "R7";
      else if (br_cond <= 3'd4) br_tag = "R8";
      else br_tag = "R9";
    end
    m_done = br_valid;
    if (cmp_valid) begin
      a = sx(cmp_first);
      b = sx(cmp_second);
      d = b - a;
      m_ov = (d > (1 << (DW - 1)) - 1) || (d < -(1 << (DW - 1)));
      m_z = (a == b);
      m_n = (a > b);
      if (m_ov) flag_tag = "R4";
      else if (a == b) flag_tag = "R1";
      else if (b > a) flag_tag = "R2";
      else flag_tag = "R3";
    end else flag_tag = "R5";
    @(negedge clk);
    chk(flag_tag, "flags{ov,z,n}", {flag_ov, flag_z, flag_n}, {m_ov, m_z, m_n});
    chk("R11", "br_done", br_done, m_done);
    if (m_done) begin
      chk(br_tag, "br_taken", br_taken, m_taken);
      chk(m_taken ? br_tag : "R10", "br_next_pc", int'(br_next_pc), m_pc);
    end else begin
      chk("R11", "br_taken hold", br_taken, m_taken);
      chk("R11", "br_next_pc hold", int'(br_next_pc), m_pc);
    end
  endtask

  task automatic drive(input bit cv, input int f, input int s, input bit bv,
                       input int c, input int tgt, input int pc, input int len);
    cmp_valid  = cv;
    cmp_first  = DW'(f);
    cmp_second = DW'(s);
    br_valid   = bv;
    br_cond    = 3'(c);
    br_target  = AW'(tgt);
    pc_cur     = AW'(pc);
    instr_len  = LW'(len);
    step();
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_ov = 0; m_z = 0; m_n = 0; m_done = 0; m_taken = 0; m_pc = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R5", "reset flags", {flag_ov, flag_z, flag_n}, 0);
    chk("R11", "reset br_done", br_done, 0);
    chk("R11", "reset br_next_pc", int'(br_next_pc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 equal, then eq/ne branches
    drive(1, 5, 5, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 1, 16'h0200, 16'h0100, 2);
    drive(0, 0, 0, 1, 2, 16'h0200, 16'h0100, 2);
    // R2 second greater: lt taken, gt not
    drive(1, 5, 8, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 3, 16'h0300, 16'h0110, 4);
    drive(0, 0, 0, 1, 4, 16'h0300, 16'h0110, 4);
    // R3 first greater: gt taken, lt not
    drive(1, 8, 5, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 4, 16'h0400, 16'h0120, 4);
    drive(0, 0, 0, 1, 3, 16'h0400, 16'h0120, 4);
    // negative operand
    drive(1, -2, 3, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 3, 16'h0500, 16'h0130, 2);
    // R4 overflow both directions
    drive(1, 16'h7FFF, 16'h8000, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 4, 16'h0600, 16'h0140, 2);
    drive(1, 16'h8000, 16'h7FFF, 0, 0, 0, 0, 0);
    drive(0, 0, 0, 1, 3, 16'h0600, 16'h0140, 2);
    // R6 always, R9 reserved codes
    drive(0, 0, 0, 1, 0, 16'h0064, 16'h0700, 2);
    for (int c = 5; c < 8; c++) drive(0, 0, 0, 1, c, 16'h0800, 16'h0700, 2);
    // R10 wrap of the sequential address
    drive(0, 0, 0, 1, 7, 16'h0800, 16'hFFFE, 4);
    // R5 hold with idle cycles and changing operands
    drive(0, 1, 9, 0, 0, 0, 0, 0);
    drive(0, 9, 1, 0, 0, 0, 0, 0);
    // R12 collision: held equal, new compare unequal
    drive(1, 3, 3, 0, 0, 0, 0, 0);
    drive(1, 3, 4, 1, 1, 16'h0900, 16'h0200, 2);
    drive(1, 4, 4, 1, 1, 16'h0900, 16'h0200, 2);
    drive(1, 9, 1, 1, 4, 16'h0A00, 16'h0210, 2);
    drive(0, 0, 0, 1, 4, 16'h0A00, 16'h0210, 2);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      int s, f;
      s = int'($urandom_range(0, 65535));
      case ($urandom_range(0, 3))
        0: f = s;
        1: f = s ^ 16'h8000;
        default: f = int'($urandom_range(0, 65535));
      endcase
      drive(bit'($urandom_range(0, 1)), f, s, bit'($urandom_range(0, 1)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)),
            int'($urandom_range(0, 65535)), int'($urandom_range(0, 15)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule